// File: doc/BRIEF.md
# Coprocessor Request Permission Checker

This block stands between the instruction pipeline and the coprocessor dispatch logic. It decides whether a coprocessor-request instruction issued by a hardware thread may proceed. Each request carries the issuing thread number, the privilege level of the issuing code, a 6-bit coprocessor type and the effective address of the request block in memory. One clock after the request is taken, the block returns a verdict: accept, alignment interrupt, or data-storage interrupt for an unavailable coprocessor type.

Each thread owns a 64-bit availability mask. Its bits are numbered from 0 at the most significant end, and bit N stands for coprocessor type N. Only the low 32 bits (types 32..63) hold state. The high half is reserved: it reads as zero and ignores writes. Software reads and writes the masks through a special-register port. Problem-state code is checked against its thread's mask. Privileged and hypervisor code bypasses that check. An address that is not a multiple of 128 is always refused first.

Top module: `copreq_guard`

## Requirements
- R1: After reset every thread's mask reads as zero, `rsp_valid` is low, and problem-state requests of any type are refused as unavailable.
- R2: A request whose address has any of its low 7 bits set gets code 1 (alignment). This holds for every privilege level and every mask value, and takes priority over the mask check.
- R3: An aligned request at privilege code 1 (privileged), 2 or 3 (hypervisor) gets code 0 (accept) whatever the mask holds.
- R4: An aligned request at privilege code 0 (problem) gets code 0 if its type bit in the issuing thread's mask is one, and code 2 (unavailable type) if it is zero.
- R5: Type N corresponds to bit 63-N of the 64-bit value on the special-register write and read data buses.
- R6: Bits 63..32 of a mask always read as zero and writes to them are ignored. Problem-state requests for types 0..31 therefore always get code 2.
- R7: Each thread's mask is independent. A write to one thread changes neither the verdicts nor the read value of any other thread.
- R8: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` and `req_ready` both high, and `rsp_code` holds the verdict for that request.
- R9: A mask write in the same cycle as a request from the same thread affects later requests, not that one.
- R10: `req_ready` is low while reset is asserted and high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| spr_wr_en | input | 1 | Mask write strobe |
| spr_wr_tid | input | 2 | Thread whose mask is written |
| spr_wr_data | input | 64 | Write data, type N at bit 63-N |
| spr_rd_tid | input | 2 | Thread whose mask is read |
| spr_rd_data | output | 64 | Read data of the selected mask |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Checker can take a request |
| req_tid | input | 2 | Issuing thread |
| req_priv | input | 2 | 0 problem, 1 privileged, 2/3 hypervisor |
| req_ctype | input | 6 | Coprocessor type |
| req_ea | input | 64 | Effective address of the request block |
| rsp_valid | output | 1 | Verdict valid |
| rsp_code | output | 2 | 0 accept, 1 alignment, 2 unavailable type |

## Verification
A corrupted mask bit shows up on the read port right after the write. It also shows up in the verdict of the next problem-state request for that type, which arrives one clock after the strobe. A mistake in the bit-order mapping or in the reserved half gives the wrong code for the types at the ends of the range (0, 31, 32, 63). A wrong priority or a wrong privilege decode gives a wrong code in the first response for a misaligned or supervisor request. Same-cycle write ordering is probed directly, because reading the new value too early changes exactly one verdict.

// File: rtl/copreq_pkg.sv
package copreq_pkg;

    localparam int MASK_W    = 64;
    localparam int IMPL_W    = 32;
    localparam int CT_W      = $clog2(MASK_W);
    localparam int ALIGN_LOG = 7;

    typedef logic [CT_W-1:0] ctype_t;

    typedef enum logic [1:0] {
        PRIV_PROBLEM = 2'd0,
        PRIV_SUPER   = 2'd1,
        PRIV_HYPER   = 2'd2,
        PRIV_HYPER2  = 2'd3
    } priv_e;

    typedef enum logic [1:0] {
        VERDICT_ACCEPT  = 2'd0,
        VERDICT_ALIGN   = 2'd1,
        VERDICT_UNAVAIL = 2'd2
    } verdict_e;

    function automatic logic [MASK_W-1:0] widen_mask(input logic [IMPL_W-1:0] impl);
        return {{(MASK_W-IMPL_W){1'b0}}, impl};
    endfunction

    function automatic logic type_enabled(input logic [MASK_W-1:0] arch, input ctype_t ct);
        ctype_t idx;
        idx = ctype_t'(MASK_W-1) - ct;
        return arch[idx];
    endfunction

endpackage

// File: rtl/copreq_maskbank.sv
module copreq_maskbank
    import copreq_pkg::*;
#(
    parameter int NTHREADS = 4,
    localparam int TID_W   = (NTHREADS > 1) ? $clog2(NTHREADS) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [TID_W-1:0]   wr_tid,
    input  logic [MASK_W-1:0]  wr_data,
    input  logic [TID_W-1:0]   rd_tid,
    output logic [MASK_W-1:0]  rd_data,
    input  logic [TID_W-1:0]   chk_tid,
    output logic [MASK_W-1:0]  chk_mask
);

    logic [IMPL_W-1:0] mask_q [NTHREADS];

    for (genvar t = 0; t < NTHREADS; t++) begin : g_thread
        always_ff @(posedge clk) begin
            if (rst) begin
                mask_q[t] <= '0;
            end else if (wr_en && (wr_tid == TID_W'(t))) begin
                mask_q[t] <= wr_data[IMPL_W-1:0];
            end
        end

        p_write_lands_r7: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_tid == TID_W'(t)) |=> (mask_q[t] == $past(wr_data[IMPL_W-1:0])));

        p_others_hold_r7: assert property (@(posedge clk) disable iff (rst)
            !(wr_en && wr_tid == TID_W'(t)) |=> $stable(mask_q[t]));
    end

    always_comb begin
        rd_data  = widen_mask(mask_q[rd_tid]);
        chk_mask = widen_mask(mask_q[chk_tid]);
    end

endmodule

// File: rtl/copreq_evaluator.sv
module copreq_evaluator
    import copreq_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic [MASK_W-1:0] arch_mask,
    input  priv_e             priv,
    input  ctype_t            ctype,
    input  logic [ADDR_W-1:0] ea,
    output verdict_e          verdict
);

    logic aligned;
    logic bypass;
    logic enabled;

    always_comb begin
        aligned = (ea[ALIGN_LOG-1:0] == '0);
        bypass  = (priv != PRIV_PROBLEM);
        enabled = type_enabled(arch_mask, ctype);
        if (!aligned) begin
            verdict = VERDICT_ALIGN;
        end else if (bypass || enabled) begin
            verdict = VERDICT_ACCEPT;
        end else begin
            verdict = VERDICT_UNAVAIL;
        end
    end

endmodule

// File: rtl/copreq_guard.sv
module copreq_guard
    import copreq_pkg::*;
#(
    parameter int NTHREADS = 4,
    parameter int ADDR_W   = 64,
    localparam int TID_W   = (NTHREADS > 1) ? $clog2(NTHREADS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spr_wr_en,
    input  logic [TID_W-1:0]  spr_wr_tid,
    input  logic [63:0]       spr_wr_data,
    input  logic [TID_W-1:0]  spr_rd_tid,
    output logic [63:0]       spr_rd_data,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [TID_W-1:0]  req_tid,
    input  logic [1:0]        req_priv,
    input  logic [5:0]        req_ctype,
    input  logic [ADDR_W-1:0] req_ea,
    output logic              rsp_valid,
    output logic [1:0]        rsp_code
);

    logic [MASK_W-1:0] chk_mask;
    verdict_e          verdict;
    verdict_e          code_q;
    logic              fire;

    assign req_ready = !rst;
    assign fire      = req_valid && req_ready;

    copreq_maskbank #(.NTHREADS(NTHREADS)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (spr_wr_en),
        .wr_tid   (spr_wr_tid),
        .wr_data  (spr_wr_data),
        .rd_tid   (spr_rd_tid),
        .rd_data  (spr_rd_data),
        .chk_tid  (req_tid),
        .chk_mask (chk_mask)
    );

    copreq_evaluator #(.ADDR_W(ADDR_W)) u_eval (
        .arch_mask (chk_mask),
        .priv      (priv_e'(req_priv)),
        .ctype     (ctype_t'(req_ctype)),
        .ea        (req_ea),
        .verdict   (verdict)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            code_q    <= VERDICT_ACCEPT;
        end else begin
            rsp_valid <= fire;
            if (fire) begin
                code_q <= verdict;
            end
        end
    end

    assign rsp_code = code_q;

    p_latency_r8: assert property (@(posedge clk) disable iff (rst)
        fire |=> rsp_valid);

    p_no_spurious_r8: assert property (@(posedge clk) disable iff (rst)
        !fire |=> !rsp_valid);

    p_align_first_r2: assert property (@(posedge clk) disable iff (rst)
        (fire && req_ea[ALIGN_LOG-1:0] != '0) |=> (rsp_code == VERDICT_ALIGN));

    p_bypass_r3: assert property (@(posedge clk) disable iff (rst)
        (fire && req_ea[ALIGN_LOG-1:0] == '0 && req_priv != 2'd0) |=> (rsp_code == VERDICT_ACCEPT));

    p_reserved_half_r6: assert property (@(posedge clk) disable iff (rst)
        (fire && req_ea[ALIGN_LOG-1:0] == '0 && req_priv == 2'd0 && req_ctype < 6'd32)
            |=> (rsp_code == VERDICT_UNAVAIL));

    p_read_upper_r6: assert property (@(posedge clk) disable iff (rst)
        spr_rd_data[63:32] == 32'd0);

endmodule

// File: tb/copreq_guard_test.sv
module copreq_guard_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        spr_wr_en = 1'b0;
    logic [1:0]  spr_wr_tid = '0;
    logic [63:0] spr_wr_data = '0;
    logic [1:0]  spr_rd_tid = '0;
    logic [63:0] spr_rd_data;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_tid = '0;
    logic [1:0]  req_priv = '0;
    logic [5:0]  req_ctype = '0;
    logic [63:0] req_ea = '0;
    logic        rsp_valid;
    logic [1:0]  rsp_code;

    int applied = 0;
    int miscompares = 0;
    bit done = 0;

    always #10 clk = ~clk;

    copreq_guard uut (
        .clk(clk), .rst(rst),
        .spr_wr_en(spr_wr_en), .spr_wr_tid(spr_wr_tid), .spr_wr_data(spr_wr_data),
        .spr_rd_tid(spr_rd_tid), .spr_rd_data(spr_rd_data),
        .req_valid(req_valid), .req_ready(req_ready), .req_tid(req_tid),
        .req_priv(req_priv), .req_ctype(req_ctype), .req_ea(req_ea),
        .rsp_valid(rsp_valid), .rsp_code(rsp_code)
    );

    localparam logic [1:0] P = 2'd0, S = 2'd1, H = 2'd2;
    localparam logic [1:0] ACC = 2'd0, ALN = 2'd1, UNA = 2'd2;
    localparam logic [56:0] EA_HI = 57'h0_1234_5678_9ABC;

    // {tid, priv, ctype, ea[6:0], expected code}
    localparam int NVEC = 16;
    localparam logic [18:0] VEC [NVEC] = '{
        {2'd0, P, 6'd32, 7'h00, ACC},  // R4 R5 type 32 -> bit 31
        {2'd0, P, 6'd63, 7'h00, ACC},  // R5 type 63 -> bit 0
        {2'd0, P, 6'd33, 7'h00, UNA},  // R4
        {2'd0, P, 6'd0,  7'h00, UNA},  // R6 reserved type
        {2'd0, P, 6'd31, 7'h00, UNA},  // R6 edge of reserved half
        {2'd1, P, 6'd48, 7'h00, ACC},  // R7
        {2'd1, P, 6'd55, 7'h00, ACC},
        {2'd1, P, 6'd47, 7'h00, UNA},
        {2'd1, P, 6'd56, 7'h00, UNA},
        {2'd1, P, 6'd32, 7'h00, UNA},  // R7 thread 0 bit not shared
        {2'd2, P, 6'd63, 7'h00, UNA},  // R1 untouched thread
        {2'd0, S, 6'd5,  7'h00, ACC},  // R3
        {2'd2, H, 6'd40, 7'h00, ACC},  // R3
        {2'd3, P, 6'd63, 7'h40, ALN},  // R2
        {2'd0, S, 6'd32, 7'h01, ALN},  // R2 priority over bypass
        {2'd2, 2'd3, 6'd0, 7'h7F, ALN} // R2
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        applied++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic spr_write(input logic [1:0] tid, input logic [63:0] d);
        @(negedge clk);
        spr_wr_en = 1'b1; spr_wr_tid = tid; spr_wr_data = d;
        @(negedge clk);
        spr_wr_en = 1'b0;
    endtask

    task automatic request(input logic [1:0] tid, input logic [1:0] pr,
                           input logic [5:0] ct, input logic [6:0] lo);
        @(negedge clk);
        req_valid = 1'b1; req_tid = tid; req_priv = pr; req_ctype = ct;
        req_ea = {EA_HI, lo};
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10 ready in reset", {63'd0, req_ready}, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R10 ready after reset", {63'd0, req_ready}, 64'd1);
        check("R1 rsp_valid", {63'd0, rsp_valid}, 64'd0);
        for (int t = 0; t < 4; t++) begin
            spr_rd_tid = 2'(t);
            #1 check("R1 mask reset", spr_rd_data, 64'd0);
        end
        request(2'd0, P, 6'd63, 7'h00);
        check("R1 rsp_valid", {63'd0, rsp_valid}, 64'd1);
        check("R1 problem refused", {62'd0, rsp_code}, {62'd0, UNA});

        spr_write(2'd0, 64'hFFFF_FFFF_8000_0001);
        spr_write(2'd1, 64'h0000_0000_0000_FF00);
        spr_rd_tid = 2'd0;
        #1 check("R6 R5 readback t0", spr_rd_data, 64'h0000_0000_8000_0001);
        spr_rd_tid = 2'd1;
        #1 check("R7 readback t1", spr_rd_data, 64'h0000_0000_0000_FF00);
        spr_rd_tid = 2'd2;
        #1 check("R7 readback t2", spr_rd_data, 64'd0);

        for (int i = 0; i < NVEC; i++) begin
            request(VEC[i][18:17], VEC[i][16:15], VEC[i][14:9], VEC[i][8:2]);
            check("R8 valid", {63'd0, rsp_valid}, 64'd1);
            check($sformatf("R2/R3/R4 vector %0d", i), {62'd0, rsp_code}, {62'd0, VEC[i][1:0]});
        end

        @(negedge clk);
        check("R8 idle no valid", {63'd0, rsp_valid}, 64'd0);

        // R9: write and request from thread 3 in the same cycle
        @(negedge clk);
        spr_wr_en = 1'b1; spr_wr_tid = 2'd3; spr_wr_data = 64'd1;
        req_valid = 1'b1; req_tid = 2'd3; req_priv = P; req_ctype = 6'd63;
        req_ea = {EA_HI, 7'h00};
        @(negedge clk);
        spr_wr_en = 1'b0; req_valid = 1'b0;
        check("R9 old mask used", {62'd0, rsp_code}, {62'd0, UNA});
        request(2'd3, P, 6'd63, 7'h00);
        check("R9 new mask next", {62'd0, rsp_code}, {62'd0, ACC});

        // R7: thread 0 unchanged by thread 3 write
        request(2'd0, P, 6'd63, 7'h00);
        check("R7 thread 0 kept", {62'd0, rsp_code}, {62'd0, ACC});

        // back-to-back requests R8
        @(negedge clk);
        req_valid = 1'b1; req_tid = 2'd1; req_priv = P; req_ctype = 6'd50; req_ea = {EA_HI, 7'h00};
        @(negedge clk);
        check("R8 b2b first", {62'd0, rsp_code}, {62'd0, ACC});
        req_ctype = 6'd20;
        @(negedge clk);
        req_valid = 1'b0;
        check("R8 b2b second", {62'd0, rsp_code}, {62'd0, UNA});
        check("R8 b2b valid", {63'd0, rsp_valid}, 64'd1);

        finish_run();
    end

endmodule